// File: doc/BRIEF.md
# Neutral-Walk Evolution Controller

This block drives a one-parent, one-offspring evolutionary search over the genotype of a feed-forward gate array. A host loads a functionally correct starting design into the parent store and tells the block that design's used-gate count. On each generation the block copies the parent into an offspring store. It then applies a fixed number of random gene mutations, each one legal for its gene position. It asks an external evaluator to score the offspring and waits for the evaluator's correctness flag and used-gate count.

The offspring replaces the parent only when it is correct and uses no more gates than the parent. This lets the search drift across designs of equal cost while the kept design stays correct. A strict reduction in gate count raises a one-cycle improvement pulse. The run ends at a programmable generation limit or on an external stop. The best genotype then stays readable until the next start.

The genotype holds three genes per cell, in this order: first input source, second input source, function. The output-source genes follow the cell genes. A source index below `N_IN` selects an array input. Index `N_IN + k` selects cell k.

Top module: `neutral_walk_ctrl`

## Requirements
- R1: While the block is idle or done, `seed_we_i` writes `seed_data_i` into parent gene `seed_addr_i`. `start_i` loads `init_gates_i` as the best gate count, clears the generation count, raises `busy_o` and lowers `done_o`.
- R2: Each offspring is a copy of the current parent in which `N_MUT` random gene draws have been applied, so it differs from the parent in at most `N_MUT` genes.
- R3: Every offspring gene is legal. Gene 3c and gene 3c+1 of cell c are below `N_IN + c`. Gene 3c+2 is a function code in 0..2. Output genes (address `3*N_CELLS` and up) are below `N_IN + N_CELLS`.
- R4: Positions and values come from a 32-bit maximal-length LFSR. A zero seed is replaced by a fixed nonzero value. Draws that fall out of range are discarded and retried, so the search always progresses.
- R5: `eval_req_o` rises only while busy and stays high until `eval_ack_i`. While it is high, `eval_gene_o` returns offspring gene `eval_addr_i`.
- R6: On an acknowledge with `eval_correct_i` = 1 and `eval_gates_i` no greater than the best count, the offspring becomes the parent and `eval_gates_i` becomes the best count. This includes equal cost.
- R7: An incorrect offspring, or one with a higher gate count, leaves the parent genotype and the best count unchanged.
- R8: `improve_o` pulses for exactly one cycle after an acceptance with a strictly lower gate count, and at no other time.
- R9: `gen_count_o` increases by one per acknowledged generation. When it reaches `gen_limit_i` (sampled at start), the block enters done.
- R10: `stop_i` during a run enters done on the next edge. The offspring in flight is discarded and the generation count is not advanced.
- R11: Seed writes issued while busy have no effect on the parent genotype.
- R12: In done, `done_o` stays high, `eval_req_o` stays low and the best genotype stays readable until the next `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| seed_we_i | input | 1 | Parent gene write strobe (idle/done only) |
| seed_addr_i | input | ADDR_W | Parent gene write address |
| seed_data_i | input | IDX_W | Parent gene write value |
| init_gates_i | input | GATE_W | Gate count of the seeded design |
| rng_seed_i | input | 32 | LFSR seed, loaded at start |
| gen_limit_i | input | GEN_W | Generation limit, loaded at start |
| start_i | input | 1 | Begin a run |
| stop_i | input | 1 | End the run early |
| eval_req_o | output | 1 | Offspring ready for evaluation |
| eval_ack_i | input | 1 | Evaluation result valid |
| eval_correct_i | input | 1 | Offspring is functionally correct |
| eval_gates_i | input | GATE_W | Offspring used-gate count |
| eval_addr_i | input | ADDR_W | Offspring gene read address |
| eval_gene_o | output | IDX_W | Offspring gene read data |
| best_addr_i | input | ADDR_W | Parent gene read address |
| best_gene_o | output | IDX_W | Parent gene read data |
| best_gates_o | output | GATE_W | Gate count of the kept design |
| gen_count_o | output | GEN_W | Generations evaluated this run |
| improve_o | output | 1 | Strict-improvement pulse |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished |

## Verification
The bench plays the evaluator and returns a scripted sequence of results. The sequence covers a strictly better correct offspring, an incorrect one with a tempting low count, a correct one of equal cost, and a correct one of higher cost. Together these separate the acceptance rule from its likely mistakes: a strict-only compare, dropping the correctness gate, or a non-strict improvement pulse.

Each offspring is read back through the evaluation port and compared with the parent. This checks the legal range of every gene and bounds how many genes changed. A seed write during a rejected generation, an early stop, and a zero LFSR seed cover the remaining corners.

// File: rtl/nwc_pkg.sv
package nwc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COPY,
    ST_MUT,
    ST_REQ,
    ST_DONE
  } state_e;

  localparam int unsigned FUNC_CODES = 3;
  localparam logic [31:0] LFSR_FALLBACK = 32'h1;

  // exclusive upper bound of the legal value for gene g
  function automatic int unsigned gene_limit(int unsigned g, int unsigned n_in,
                                             int unsigned n_cells);
    if (g < 3 * n_cells) begin
      if (g % 3 == 2) return FUNC_CODES;
      return n_in + g / 3;
    end
    return n_in + n_cells;
  endfunction

endpackage

// File: rtl/nwc_lfsr.sv
module nwc_lfsr (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [31:0] seed_i,
  input  logic        step_i,
  output logic [31:0] state_o
);
  logic [31:0] lfsr_q;
  logic        fb;

  // x^32 + x^22 + x^2 + x + 1
  assign fb = lfsr_q[31] ^ lfsr_q[21] ^ lfsr_q[1] ^ lfsr_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lfsr_q <= nwc_pkg::LFSR_FALLBACK;
    else if (load_i) lfsr_q <= (seed_i == '0) ? nwc_pkg::LFSR_FALLBACK : seed_i;
    else if (step_i) lfsr_q <= {lfsr_q[30:0], fb};
  end

  assign state_o = lfsr_q;
endmodule

// File: rtl/nwc_gene_check.sv
module nwc_gene_check #(
  parameter int unsigned N_IN    = 4,
  parameter int unsigned N_CELLS = 8,
  parameter int unsigned N_GENES = 26,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [ADDR_W-1:0] pos_i,
  input  logic [IDX_W-1:0]  val_i,
  output logic              ok_o
);
  always_comb begin
    ok_o = 1'b0;
    if (32'(pos_i) < N_GENES)
      ok_o = 32'(val_i) < nwc_pkg::gene_limit(32'(pos_i), N_IN, N_CELLS);
  end
endmodule

// File: rtl/nwc_gene_store.sv
module nwc_gene_store #(
  parameter int unsigned N_GENES = 26,
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned IDX_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_we_i,
  input  logic [ADDR_W-1:0] seed_addr_i,
  input  logic [IDX_W-1:0]  seed_data_i,
  input  logic              commit_i,
  input  logic              copy_i,
  input  logic              mut_we_i,
  input  logic [ADDR_W-1:0] mut_addr_i,
  input  logic [IDX_W-1:0]  mut_data_i,
  input  logic [ADDR_W-1:0] par_addr_i,
  output logic [IDX_W-1:0]  par_gene_o,
  input  logic [ADDR_W-1:0] chd_addr_i,
  output logic [IDX_W-1:0]  chd_gene_o
);
  logic [IDX_W-1:0] par_q [N_GENES];
  logic [IDX_W-1:0] chd_q [N_GENES];

  for (genvar g = 0; g < N_GENES; g++) begin : g_gene
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) par_q[g] <= '0;
      else if (seed_we_i && seed_addr_i == ADDR_W'(g)) par_q[g] <= seed_data_i;
      else if (commit_i) par_q[g] <= chd_q[g];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chd_q[g] <= '0;
      else if (copy_i) chd_q[g] <= par_q[g];
      else if (mut_we_i && mut_addr_i == ADDR_W'(g)) chd_q[g] <= mut_data_i;
    end
  end

  always_comb begin
    par_gene_o = '0;
    chd_gene_o = '0;
    for (int g = 0; g < N_GENES; g++) begin
      if (par_addr_i == ADDR_W'(g)) par_gene_o = par_q[g];
      if (chd_addr_i == ADDR_W'(g)) chd_gene_o = chd_q[g];
    end
  end
endmodule

// File: rtl/neutral_walk_ctrl.sv
module neutral_walk_ctrl #(
  parameter int unsigned N_IN    = 4,
  parameter int unsigned N_CELLS = 8,
  parameter int unsigned N_OUT   = 2,
  parameter int unsigned N_MUT   = 2,
  parameter int unsigned GATE_W  = 8,
  parameter int unsigned GEN_W   = 24,
  localparam int unsigned N_GENES = 3 * N_CELLS + N_OUT,
  localparam int unsigned ADDR_W  = $clog2(N_GENES),
  localparam int unsigned IDX_W   = $clog2(N_IN + N_CELLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              seed_we_i,
  input  logic [ADDR_W-1:0] seed_addr_i,
  input  logic [IDX_W-1:0]  seed_data_i,
  input  logic [GATE_W-1:0] init_gates_i,
  input  logic [31:0]       rng_seed_i,
  input  logic [GEN_W-1:0]  gen_limit_i,
  input  logic              start_i,
  input  logic              stop_i,
  output logic              eval_req_o,
  input  logic              eval_ack_i,
  input  logic              eval_correct_i,
  input  logic [GATE_W-1:0] eval_gates_i,
  input  logic [ADDR_W-1:0] eval_addr_i,
  output logic [IDX_W-1:0]  eval_gene_o,
  input  logic [ADDR_W-1:0] best_addr_i,
  output logic [IDX_W-1:0]  best_gene_o,
  output logic [GATE_W-1:0] best_gates_o,
  output logic [GEN_W-1:0]  gen_count_o,
  output logic              improve_o,
  output logic              busy_o,
  output logic              done_o
);
  import nwc_pkg::*;

  localparam int unsigned CNT_W = $clog2(N_MUT + 1);
  localparam logic [CNT_W-1:0] MUT_LAST = CNT_W'(N_MUT - 1);

  state_e            st_q;
  logic [CNT_W-1:0]  mut_cnt_q;
  logic [GATE_W-1:0] best_gates_q;
  logic [GEN_W-1:0]  gen_q, limit_q;
  logic              improve_q;
  logic [31:0]       rng;
  logic              idle_like, running, start_acc, draw_ok, accept, lower, last_gen;
  logic [ADDR_W-1:0] draw_pos;
  logic [IDX_W-1:0]  draw_val;

  assign idle_like = (st_q == ST_IDLE) || (st_q == ST_DONE);
  assign running   = (st_q == ST_COPY) || (st_q == ST_MUT) || (st_q == ST_REQ);
  assign start_acc = idle_like && start_i;
  assign draw_pos  = rng[ADDR_W-1:0];
  assign draw_val  = rng[31 -: IDX_W];
  assign lower     = eval_gates_i < best_gates_q;
  assign accept    = eval_correct_i && (eval_gates_i <= best_gates_q);
  assign last_gen  = ({1'b0, gen_q} + 1'b1) >= {1'b0, limit_q};

  nwc_lfsr u_lfsr (
    .clk_i, .rst_ni,
    .load_i (start_acc),
    .seed_i (rng_seed_i),
    .step_i (st_q == ST_MUT),
    .state_o(rng)
  );

  nwc_gene_check #(
    .N_IN(N_IN), .N_CELLS(N_CELLS), .N_GENES(N_GENES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_check (
    .pos_i(draw_pos),
    .val_i(draw_val),
    .ok_o (draw_ok)
  );

  nwc_gene_store #(
    .N_GENES(N_GENES), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_store (
    .clk_i, .rst_ni,
    .seed_we_i  (seed_we_i && idle_like),
    .seed_addr_i(seed_addr_i),
    .seed_data_i(seed_data_i),
    .commit_i   (st_q == ST_REQ && eval_ack_i && !stop_i && accept),
    .copy_i     (st_q == ST_COPY),
    .mut_we_i   (st_q == ST_MUT && draw_ok),
    .mut_addr_i (draw_pos),
    .mut_data_i (draw_val),
    .par_addr_i (best_addr_i),
    .par_gene_o (best_gene_o),
    .chd_addr_i (eval_addr_i),
    .chd_gene_o (eval_gene_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      mut_cnt_q    <= '0;
      best_gates_q <= '0;
      gen_q        <= '0;
      limit_q      <= '0;
      improve_q    <= 1'b0;
    end else begin
      improve_q <= 1'b0;
      if (running && stop_i) begin
        st_q <= ST_DONE;
      end else begin
        unique case (st_q)
          ST_IDLE, ST_DONE: if (start_i) begin
            best_gates_q <= init_gates_i;
            gen_q        <= '0;
            limit_q      <= gen_limit_i;
            st_q         <= ST_COPY;
          end
          ST_COPY: begin
            mut_cnt_q <= '0;
            st_q      <= ST_MUT;
          end
          ST_MUT: if (draw_ok) begin
            mut_cnt_q <= mut_cnt_q + 1'b1;
            if (mut_cnt_q == MUT_LAST) st_q <= ST_REQ;
          end
          ST_REQ: if (eval_ack_i) begin
            gen_q <= gen_q + 1'b1;
            if (accept) begin
              best_gates_q <= eval_gates_i;
              improve_q    <= lower;
            end
            st_q <= last_gen ? ST_DONE : ST_COPY;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign eval_req_o   = st_q == ST_REQ;
  assign best_gates_o = best_gates_q;
  assign gen_count_o  = gen_q;
  assign improve_o    = improve_q;
  assign busy_o       = running;
  assign done_o       = st_q == ST_DONE;
endmodule

// File: rtl/nwc_chk.sv
module nwc_chk #(
  parameter int unsigned GATE_W = 8,
  parameter int unsigned GEN_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              stop_i,
  input logic              eval_req_o,
  input logic              eval_ack_i,
  input logic [GATE_W-1:0] best_gates_o,
  input logic [GEN_W-1:0]  gen_count_o,
  input logic              improve_o,
  input logic              busy_o,
  input logic              done_o
);
  a_r5_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_req_o && !eval_ack_i && !stop_i |=> eval_req_o);

  a_r5_req_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_req_o |-> busy_o);

  a_r8_improve_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    improve_o |-> best_gates_o < $past(best_gates_o));

  a_r7_gates_never_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> best_gates_o <= $past(best_gates_o));

  a_r9_gen_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> (gen_count_o == $past(gen_count_o)) ||
                      (gen_count_o == $past(gen_count_o) + GEN_W'(1)));

  a_r10_stop_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && stop_i |=> done_o);

  a_r12_done_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && !eval_req_o);
endmodule

bind neutral_walk_ctrl nwc_chk #(.GATE_W(GATE_W), .GEN_W(GEN_W)) u_chk (
  .clk_i, .rst_ni, .start_i, .stop_i, .eval_req_o, .eval_ack_i,
  .best_gates_o, .gen_count_o, .improve_o, .busy_o, .done_o
);

// File: tb/neutral_walk_ctrl_test.sv
module neutral_walk_ctrl_test;
  localparam int NI = 4, NC = 8, NO = 2, NM = 2, GW = 8, NW = 24;
  localparam int NG = 3 * NC + NO;
  localparam int AW = $clog2(NG);
  localparam int IW = $clog2(NI + NC);
  localparam int NV = 8;
  // {correct, gates}; best starts at 10
  localparam logic [8:0] VEC [NV] = '{
    {1'b1, 8'd9}, {1'b0, 8'd5}, {1'b1, 8'd9}, {1'b1, 8'd10},
    {1'b1, 8'd7}, {1'b0, 8'd7}, {1'b1, 8'd7}, {1'b1, 8'd3}};

  logic clk_i = 0, rst_ni = 0;
  logic seed_we_i = 0, start_i = 0, stop_i = 0, eval_ack_i = 0, eval_correct_i = 0;
  logic [AW-1:0] seed_addr_i = '0, eval_addr_i = '0, best_addr_i = '0;
  logic [IW-1:0] seed_data_i = '0, eval_gene_o, best_gene_o;
  logic [GW-1:0] init_gates_i = '0, eval_gates_i = '0, best_gates_o;
  logic [31:0]   rng_seed_i = '0;
  logic [NW-1:0] gen_limit_i = '0, gen_count_o;
  logic eval_req_o, improve_o, busy_o, done_o;

  int checks = 0, fails = 0, exp_best = 0;
  bit finished = 0;
  logic [IW-1:0] par_s [NG];
  logic [IW-1:0] off_s [NG];

  always #10 clk_i = ~clk_i;

  neutral_walk_ctrl uut (.*);

  function automatic int lim(int g);
    if (g < 3 * NC) return (g % 3 == 2) ? 3 : NI + g / 3;
    return NI + NC;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic wait_req(output bit seen);
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(posedge clk_i); #1;
      seen = eval_req_o;
    end
  endtask

  task automatic start_run(int gates, logic [31:0] seed, int limit);
    @(negedge clk_i);
    init_gates_i = GW'(gates); rng_seed_i = seed; gen_limit_i = NW'(limit); start_i = 1;
    @(posedge clk_i); #1; start_i = 0;
    exp_best = gates;
  endtask

  // act as evaluator for one generation
  task automatic serve(bit cor, int gates, bit poke);
    bit seen, acc, imp;
    int diff, bad, g0, gen_before;
    wait_req(seen);
    chk(seen, "R5 request raised", int'(seen), 1);
    if (!seen) return;
    gen_before = int'(gen_count_o);
    diff = 0; bad = 0;
    for (int g = 0; g < NG; g++) begin
      eval_addr_i = AW'(g); best_addr_i = AW'(g); #1;
      off_s[g] = eval_gene_o; par_s[g] = best_gene_o;
      if (int'(off_s[g]) >= lim(g)) bad++;
      if (off_s[g] != par_s[g]) diff++;
    end
    chk(bad == 0, "R3 offspring genes legal", bad, 0);
    chk(diff <= NM, "R2 mutated gene count", diff, NM);
    @(negedge clk_i);
    if (poke) begin
      seed_we_i = 1; seed_addr_i = '0; seed_data_i = par_s[0] ^ IW'(1);
    end
    @(posedge clk_i); #1;
    chk(eval_req_o, "R5 request held without ack", int'(eval_req_o), 1);
    @(negedge clk_i);
    seed_we_i = 0;
    eval_ack_i = 1; eval_correct_i = cor; eval_gates_i = GW'(gates);
    acc = cor && gates <= exp_best;
    imp = cor && gates < exp_best;
    @(posedge clk_i); #1;
    eval_ack_i = 0;
    chk(improve_o == imp, "R8 improve pulse", int'(improve_o), int'(imp));
    if (acc) exp_best = gates;
    chk(int'(best_gates_o) == exp_best, acc ? "R6 best gates" : "R7 best gates",
        int'(best_gates_o), exp_best);
    chk(int'(gen_count_o) == gen_before + 1, "R9 generation count",
        int'(gen_count_o), gen_before + 1);
    chk(!eval_req_o, "R5 request dropped after ack", int'(eval_req_o), 0);
    bad = 0;
    for (int g = 0; g < NG; g++) begin
      best_addr_i = AW'(g); #1;
      if (best_gene_o != (acc ? off_s[g] : par_s[g])) bad++;
    end
    chk(bad == 0, acc ? "R6 parent replaced" : "R7 parent kept", bad, 0);
    if (poke) begin
      best_addr_i = '0; #1; g0 = int'(best_gene_o);
      chk(best_gene_o == (acc ? off_s[0] : par_s[0]), "R11 seed write ignored",
          g0, int'(par_s[0]));
    end
    @(posedge clk_i); #1;
    chk(!improve_o, "R8 pulse one cycle", int'(improve_o), 0);
  endtask

  initial begin
    bit seen;
    int bad;
    #5;
    chk(!busy_o && !done_o && !eval_req_o && gen_count_o == '0, "R1 reset state",
        int'(busy_o) + int'(done_o) + int'(eval_req_o), 0);
    @(negedge clk_i); rst_ni = 1;
    for (int g = 0; g < NG; g++) begin
      @(negedge clk_i);
      seed_we_i = 1; seed_addr_i = AW'(g); seed_data_i = IW'((g * 5 + 1) % lim(g));
    end
    @(negedge clk_i); seed_we_i = 0;
    bad = 0;
    for (int g = 0; g < NG; g++) begin
      best_addr_i = AW'(g); #1;
      if (int'(best_gene_o) != (g * 5 + 1) % lim(g)) bad++;
    end
    chk(bad == 0, "R1 seed loaded", bad, 0);

    start_run(10, 32'hACE1_2468, NV);
    chk(busy_o && !done_o && int'(best_gates_o) == 10 && gen_count_o == '0,
        "R1 start state", int'(best_gates_o), 10);
    for (int v = 0; v < NV; v++) begin
      serve(VEC[v][8], int'(VEC[v][7:0]), v == 1);
    end
    chk(done_o && !busy_o, "R9 done at limit", int'(done_o), 1);
    repeat (5) @(posedge clk_i);
    #1;
    chk(done_o && !eval_req_o && int'(best_gates_o) == 3, "R12 done holds",
        int'(best_gates_o), 3);

    // early stop
    start_run(20, 32'h1357_9BDF, 100);
    serve(1, 20, 0);
    serve(1, 20, 0);
    wait_req(seen);
    @(negedge clk_i); stop_i = 1;
    @(posedge clk_i); #1; stop_i = 0;
    chk(done_o && !eval_req_o && int'(gen_count_o) == 2 && int'(best_gates_o) == 20,
        "R10 stop ends run", int'(gen_count_o), 2);

    // zero LFSR seed still progresses
    start_run(6, 32'h0, 1);
    serve(1, 5, 0);
    chk(done_o && int'(best_gates_o) == 5, "R4 zero seed progresses",
        int'(best_gates_o), 5);
    finish_run();
  end
endmodule